// File: doc/BRIEF.md
# System Control Port Register

This block is one byte-wide control register on a simple host I/O bus. It answers at a single fixed I/O address (0x0092 by default). A write stores the whole byte and a read returns it. Two of the stored bits control the system directly. Bit 1 drives the gate level for address line 20. Bit 0 asks the system reset controller for a reset, but only when it goes from 0 to 1.

The reset request leaves the block as a registered pulse one clock wide. It appears in the cycle after the qualifying write. The block has two resets. An asynchronous power-on reset clears the whole byte. A synchronous warm reset, driven by the system reset controller after it has acted on the request, clears only bit 0. The A20 gate level therefore survives a warm reset, and software can request a reset again later.

Top module: `sysctl_port`

## Requirements
- R1: After power-on reset (por_n low) the stored byte is 0x00, gate_a20 is 0 and rst_req is 0.
- R2: Only address 0x0092 selects the register. A write to any other address leaves the stored byte unchanged, and a read at another address returns 0x00.
- R3: A write (wr_en high at 0x0092) stores all 8 bits of wdata. A read (rd_en high at 0x0092) returns the stored byte on rdata in the same cycle. With rd_en low, rdata is 0x00.
- R4: gate_a20 equals bit 1 of the stored byte. It takes the new value at the clock edge that stores the write.
- R5: rst_req is high for exactly one cycle, the cycle after a write that sets bit 0 while the stored bit 0 was 0. A write with bit 0 set over a stored bit 0 of 1 raises no pulse.
- R6: warm_rst clears stored bit 0 and keeps bits 7..1, so gate_a20 keeps its level.
- R7: When a write and warm_rst fall in the same cycle, bits 7..1 come from wdata, bit 0 ends at 0, and no reset pulse is raised.
- R8: A read never changes the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst | input | 1 | Synchronous warm reset, active high, clears bit 0 |
| addr | input | 16 | I/O address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0x00 when not selected |
| gate_a20 | output | 1 | Address line 20 gate level (stored bit 1) |
| rst_req | output | 1 | One-cycle reset request pulse |

## Verification
The hardest case to reach is a second reset request. Bit 0 stays set after the first request, so further writes of 1 must stay silent. A new pulse can only come after bit 0 has been cleared again, either by a write of 0 or by a warm reset. The stimulus builds these histories on purpose: repeated writes of 0x01, a 0/1/0/1 toggle, a warm reset arriving between writes, and a warm reset landing in the same cycle as a write that sets bit 0. Pulses are counted across each history, and every cycle is compared against a reference byte.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int SC_DATA_W = 8;
  typedef logic [SC_DATA_W-1:0] sc_byte_t;

  // Value held after one clock edge.
  function automatic sc_byte_t sc_next(sc_byte_t old_v, sc_byte_t wd, logic wr, logic warm, int rbit);
    sc_byte_t n;
    n = wr ? wd : old_v;
    if (warm) n[rbit] = 1'b0;
    return n;
  endfunction

  // True when this cycle qualifies for a reset request.
  function automatic logic sc_rise(sc_byte_t old_v, sc_byte_t wd, logic wr, logic warm, int rbit);
    return wr && !warm && wd[rbit] && !old_v[rbit];
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
  parameter int ADDR_W    = 16,
  parameter int PORT_ADDR = 'h92
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic              wr_hit,
  output logic              rd_hit
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(PORT_ADDR);
  logic sel;
  assign sel    = (addr == MATCH);
  assign wr_hit = sel && wr_en;
  assign rd_hit = sel && rd_en;
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int RST_BIT = 0
) (
  input  logic     clk,
  input  logic     por_n,
  input  logic     warm_rst,
  input  logic     wr_hit,
  input  sc_byte_t wdata,
  output sc_byte_t stored,
  output logic     rise_evt
);
  sc_byte_t nxt;
  assign nxt      = sc_next(stored, wdata, wr_hit, warm_rst, RST_BIT);
  assign rise_evt = sc_rise(stored, wdata, wr_hit, warm_rst, RST_BIT);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) stored <= '0;
    else        stored <= nxt;
  end
endmodule

// File: rtl/sysctl_pulse.sv
module sysctl_pulse (
  input  logic clk,
  input  logic por_n,
  input  logic rise_evt,
  output logic pulse
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) pulse <= 1'b0;
    else        pulse <= rise_evt;
  end
endmodule

// File: rtl/sysctl_port.sv
module sysctl_port
  import sysctl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PORT_ADDR = 'h92,
  parameter int RST_BIT   = 0,
  parameter int GATE_BIT  = 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              gate_a20,
  output logic              rst_req
);
  logic     wr_hit;
  logic     rd_hit;
  logic     rise_evt;
  sc_byte_t stored;

  sysctl_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  sysctl_store #(.RST_BIT(RST_BIT)) u_store (
    .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .wr_hit(wr_hit),
    .wdata(wdata), .stored(stored), .rise_evt(rise_evt)
  );

  sysctl_pulse u_pulse (
    .clk(clk), .por_n(por_n), .rise_evt(rise_evt), .pulse(rst_req)
  );

  assign gate_a20 = stored[GATE_BIT];
  assign rdata    = rd_hit ? stored : '0;
endmodule

// File: rtl/sysctl_port_chk.sv
module sysctl_port_chk (
  input logic       clk,
  input logic       por_n,
  input logic       warm_rst,
  input logic       wr_hit,
  input logic [7:0] wdata,
  input logic [7:0] stored,
  input logic       gate_a20,
  input logic       rst_req
);
  AST_STORE_WRITE: assert property (@(posedge clk) disable iff (!por_n)
    wr_hit |=> stored[7:1] == $past(wdata[7:1])); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!por_n)
    (!wr_hit && !warm_rst) |=> $stable(stored)); // R2
  AST_GATE_TRACK: assert property (@(posedge clk) disable iff (!por_n)
    wr_hit |=> gate_a20 == $past(wdata[1])); // R4
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |-> $past(wr_hit && wdata[0] && !stored[0] && !warm_rst)); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |=> !rst_req); // R5
  AST_WARM_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    warm_rst |=> !stored[0]); // R6
  AST_WARM_KEEP: assert property (@(posedge clk) disable iff (!por_n)
    (warm_rst && !wr_hit) |=> stored[7:1] == $past(stored[7:1])); // R6
  AST_COLLIDE_QUIET: assert property (@(posedge clk) disable iff (!por_n)
    (warm_rst && wr_hit) |=> !rst_req); // R7
endmodule

bind sysctl_port sysctl_port_chk u_chk (
  .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .wr_hit(wr_hit),
  .wdata(wdata), .stored(stored), .gate_a20(gate_a20), .rst_req(rst_req)
);

// File: tb/sim_sysctl_port.sv
`timescale 1ns/1ps
module sim_sysctl_port;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        warm_rst = 1'b0;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        gate_a20;
  logic        rst_req;

  always #4 clk = ~clk;

  sysctl_port u0 (
    .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .gate_a20(gate_a20), .rst_req(rst_req)
  );

  typedef struct {
    logic  req;
    logic  gate;
    string tag;
  } exp_t;

  exp_t        sb[$];
  logic [7:0]  mdl = 8'h00;
  int          checks = 0;
  int          fails = 0;
  int          pulses = 0;
  bit          done = 1'b0;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive, predict, queue the registered outcome.
  task automatic step(input bit wr, input bit rd, input bit warm,
                      input logic [15:0] a, input logic [7:0] d, input string tag);
    logic       hit;
    logic [7:0] nv;
    exp_t       e;
    @(negedge clk);
    wr_en = wr; rd_en = rd; warm_rst = warm; addr = a; wdata = d;
    hit = (a == 16'h0092);
    #1;
    check({tag, " rdata"}, rdata, (rd && hit) ? mdl : 8'h00);
    nv = (wr && hit) ? d : mdl;
    if (warm) nv[0] = 1'b0;
    e.req  = wr && hit && !warm && d[0] && !mdl[0];
    e.gate = nv[1];
    e.tag  = tag;
    sb.push_back(e);
    mdl = nv;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 16'h0000, 8'h00, "R5 idle");
  endtask

  // Monitor: compares registered outputs just after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_req) pulses++;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " R5 rst_req"}, {7'b0, rst_req}, {7'b0, e.req});
        check({e.tag, " R4 gate_a20"}, {7'b0, gate_a20}, {7'b0, e.gate});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset rst_req", {7'b0, rst_req}, 8'h00);
    check("R1 reset gate", {7'b0, gate_a20}, 8'h00);
    @(negedge clk);
    por_n = 1'b1;
    step(0, 1, 0, 16'h0092, 8'h00, "R1 read");

    step(1, 0, 0, 16'h0092, 8'hA5, "R3 write A5");
    step(0, 1, 0, 16'h0092, 8'h00, "R3 readback");
    step(0, 0, 0, 16'h0092, 8'h00, "R3 no rd");

    // Repeated writes of 0x01: exactly one pulse.
    step(1, 0, 0, 16'h0092, 8'h00, "R5 clear");
    idle(1);
    base = pulses;
    for (int i = 0; i < 3; i++) step(1, 0, 0, 16'h0092, 8'h01, "R5 repeat");
    idle(2);
    check("R5 repeat pulse count", 8'(pulses - base), 8'd1);

    // Toggle 0,1,0,1: two pulses.
    base = pulses;
    step(1, 0, 0, 16'h0092, 8'h00, "R5 t0");
    step(1, 0, 0, 16'h0092, 8'h01, "R5 t1");
    step(1, 0, 0, 16'h0092, 8'h00, "R5 t2");
    step(1, 0, 0, 16'h0092, 8'h01, "R5 t3");
    idle(2);
    check("R5 toggle pulse count", 8'(pulses - base), 8'd2);

    // Warm reset keeps bits 7..1.
    step(1, 0, 0, 16'h0092, 8'h02, "R6 write 02");
    step(0, 0, 1, 16'h0000, 8'h00, "R6 warm");
    step(0, 1, 0, 16'h0092, 8'h00, "R6 read 02");
    step(1, 0, 0, 16'h0092, 8'h03, "R6 write 03");
    step(0, 0, 1, 16'h0000, 8'h00, "R6 warm2");
    step(0, 1, 0, 16'h0092, 8'h00, "R6 read after warm");
    base = pulses;
    step(1, 0, 0, 16'h0092, 8'h03, "R6 rearm");
    idle(2);
    check("R6 pulse after warm", 8'(pulses - base), 8'd1);

    // Other addresses.
    step(1, 0, 0, 16'h0093, 8'hFF, "R2 write 93");
    step(1, 0, 0, 16'h0192, 8'hFE, "R2 write 192");
    step(0, 1, 0, 16'h0093, 8'h00, "R2 read 93");
    step(0, 1, 0, 16'h0092, 8'h00, "R2 read unchanged");

    // Write and warm reset together.
    step(1, 0, 0, 16'h0092, 8'h00, "R7 prep");
    base = pulses;
    step(1, 0, 1, 16'h0092, 8'hFD, "R7 collide");
    idle(2);
    check("R7 collide pulse count", 8'(pulses - base), 8'd0);
    step(0, 1, 0, 16'h0092, 8'h00, "R7 read FC");

    // Reads change nothing.
    step(0, 1, 0, 16'h0092, 8'h5A, "R8 read1");
    step(0, 1, 0, 16'h0092, 8'hFF, "R8 read2");
    idle(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule